// File: doc/BRIEF.md
# Tiled Surface Address Walker

This block turns a rectangle of element coordinates into a stream of byte addresses for a surface held in one of four memory layouts: plain row-major (linear) or one of three 4 KB tile layouts, called X, Y and W here. Inside a tile, the address is built by interleaving coordinate bits in a fixed pattern for each layout, with no multiplier. Whole tiles follow each other row-major in memory. An optional channel swizzle can flip address bit 6 after the full address is formed.

A start pulse samples the configuration and a rectangle (origin, width, height). The block then walks the rectangle in raster order, x fastest, and presents one address per element on a valid/ready stream. While `out_valid` is high and `out_ready` is low, the address is held and the walk does not advance. An address moves on only on a cycle where both are high. `done` pulses one cycle after the last element is accepted.

Separately from any walk, two combinational outputs give the pitch and the total byte size of a surface whose element width and height are on `rect_w`/`rect_h`, using the current configuration.

Top module: `tile_addr_walker`

## Requirements
- R1: Linear mode (`cfg_mode`=0) emits base + y*pitch + x*bpe, where bpe = 1<<`cfg_bpe_log2`. The swizzle never applies in this mode.
- R2: X mode (`cfg_mode`=1) uses tiles 512 B wide and 8 rows tall. With ub = x*bpe, the in-tile offset is {y[2:0], ub[8:0]}.
- R3: Y mode (`cfg_mode`=2) uses tiles 128 B wide and 32 rows tall. The in-tile offset is {ub[6:4], y[4:0], ub[3:0]}, so wider elements leave the low offset bits at zero.
- R4: W mode (`cfg_mode`=3, 1-byte elements only) uses 64x64-element tiles. Offset bits 11..0 are x5 x4 x3 y5 y4 y3 y2 x2 y1 x1 y0 x0.
- R5: In tiled modes the address is base + ty*pitch*rows + tx*4096 + offset. Rows is 8 for X and 32 for Y and W. tx is ub/512 for X, ub/128 for Y and x/64 for W. ty is y/8, y/32 and y/64 respectively.
- R6: With `cfg_swz`=1, bit 6 of the finished address is XORed with bits 9 and 10 in X mode, and with bit 9 in Y mode. W and linear are left unchanged.
- R7: After an accepted start, addresses appear in raster order from the origin: x runs from org_x to org_x+w-1 for each y from org_y to org_y+h-1. `done` is high for one cycle, the cycle after the last handshake, and `out_valid` is low in that cycle.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_addr` stays unchanged on the next cycle.
- R9: A start pulse during a walk is ignored. Configuration changes during a walk do not alter the emitted addresses.
- R10: A start taken while idle sets `err` for that request if any of these hold: `cfg_bpe_log2` > 4; W mode with `cfg_bpe_log2` ≠ 0; or the pitch is not a multiple of the physical tile width (512 for X, 128 for Y/W, bpe for linear). In that case no walk begins. A legal start clears `err`, and `err` changes at no other time.
- R11: `surf_pitch` = ceil(w / tile width in elements) * physical tile width in bytes. `surf_bytes` = ceil(h / tile height) * physical rows * `surf_pitch`. Logical tiles are X (512/bpe)x8, Y (128/bpe)x32, W 64x64, and linear 1x1 with a physical width of bpe.
- R12: A legal start with zero width or height emits no element and pulses `done` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 2 | Layout: 0 linear, 1 X, 2 Y, 3 W |
| cfg_bpe_log2 | input | 3 | log2 of bytes per element (0..4) |
| cfg_base | input | AW | Surface base byte address |
| cfg_pitch | input | AW | Row pitch in bytes |
| cfg_swz | input | 1 | Bit-6 channel swizzle enable |
| start | input | 1 | Start request (taken only while idle) |
| org_x | input | CW | Rectangle origin x, in elements |
| org_y | input | CW | Rectangle origin y, in rows |
| rect_w | input | CW | Rectangle width; also the width for the size outputs |
| rect_h | input | CW | Rectangle height; also the height for the size outputs |
| out_valid | output | 1 | Address available |
| out_ready | input | 1 | Consumer accepts the address |
| out_addr | output | AW | Byte address of the current element |
| done | output | 1 | One-cycle pulse after the last element is accepted |
| err | output | 1 | Last idle start was illegal |
| surf_pitch | output | AW | Computed pitch for rect_w |
| surf_bytes | output | AW | Computed surface size for rect_w x rect_h |

## Verification
The first address is present at the first falling edge after the edge that takes the start, since only the coordinate registers lie on the way. Each later address follows one edge after a handshake. `done` and `err` each need one register, so the bench reads them at the falling edge after the deciding edge. The size outputs are pure logic and are read at the same falling edge at which their inputs are driven. Every handshake is judged at the falling edge before the edge that consumes it, and an address held under back-pressure is compared again one falling edge later.

// File: rtl/tile_pkg.sv
package tile_pkg;
  typedef enum logic [1:0] {
    TM_LINEAR = 2'd0,
    TM_X      = 2'd1,
    TM_Y      = 2'd2,
    TM_W      = 2'd3
  } tile_mode_e;

  localparam int TILE_BYTES_LOG2 = 12;
  localparam int MAX_BPE_LOG2    = 4;

  typedef enum logic {
    WK_IDLE = 1'b0,
    WK_RUN  = 1'b1
  } walk_state_e;
endpackage

// File: rtl/tile_geom.sv
module tile_geom
  import tile_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 14
) (
  input  tile_mode_e     mode,
  input  logic [2:0]     bpe_log2,
  input  logic [CW-1:0]  width,
  input  logic [CW-1:0]  height,
  input  logic [AW-1:0]  pitch,
  output logic [AW-1:0]  size_pitch,
  output logic [AW-1:0]  size_bytes,
  output logic           legal
);
  logic [3:0]    lw_log2, lh_log2, pw_log2, rows_log2;
  logic [AW-1:0] w_tiles, h_tiles, h_rows, pw_mask;

  always_comb begin
    lw_log2   = 4'd0;
    lh_log2   = 4'd0;
    pw_log2   = {1'b0, bpe_log2};
    rows_log2 = 4'd0;
    case (mode)
      TM_X: begin
        lw_log2 = 4'd9 - {1'b0, bpe_log2};
        lh_log2 = 4'd3; pw_log2 = 4'd9; rows_log2 = 4'd3;
      end
      TM_Y: begin
        lw_log2 = 4'd7 - {1'b0, bpe_log2};
        lh_log2 = 4'd5; pw_log2 = 4'd7; rows_log2 = 4'd5;
      end
      TM_W: begin
        lw_log2 = 4'd6; lh_log2 = 4'd6; pw_log2 = 4'd7; rows_log2 = 4'd5;
      end
      default: ;
    endcase
  end

  // ceiling divisions by powers of two, then the tiled footprint
  always_comb begin
    w_tiles    = (AW'(width)  + (AW'(1) << lw_log2) - AW'(1)) >> lw_log2;
    h_tiles    = (AW'(height) + (AW'(1) << lh_log2) - AW'(1)) >> lh_log2;
    size_pitch = w_tiles << pw_log2;
    h_rows     = h_tiles << rows_log2;
    size_bytes = h_rows * size_pitch;
    pw_mask    = (AW'(1) << pw_log2) - AW'(1);
    legal      = (int'(bpe_log2) <= MAX_BPE_LOG2) &&
                 !(mode == TM_W && bpe_log2 != 3'd0) &&
                 ((pitch & pw_mask) == '0);
  end
endmodule

// File: rtl/tile_addr_map.sv
module tile_addr_map
  import tile_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 14
) (
  input  tile_mode_e     mode,
  input  logic [2:0]     bpe_log2,
  input  logic           swz,
  input  logic [AW-1:0]  base,
  input  logic [AW-1:0]  pitch,
  input  logic [CW-1:0]  x,
  input  logic [CW-1:0]  y,
  output logic [AW-1:0]  addr
);
  localparam int UW = CW + 5;

  logic [UW-1:0]              ub;
  logic [TILE_BYTES_LOG2-1:0] offs;
  logic [AW-1:0]              tx, ty, step, raw;

  assign ub = UW'(x) << bpe_log2;

  // bit interleave inside a tile, tile index and tile-row stride
  always_comb begin
    offs = '0;
    tx   = '0;
    ty   = '0;
    step = '0;
    case (mode)
      TM_X: begin
        offs = {y[2:0], ub[8:0]};
        tx = AW'(ub >> 9); ty = AW'(y >> 3); step = pitch << 3;
      end
      TM_Y: begin
        offs = {ub[6:4], y[4:0], ub[3:0]};
        tx = AW'(ub >> 7); ty = AW'(y >> 5); step = pitch << 5;
      end
      TM_W: begin
        offs = {x[5:3], y[5:2], x[2], y[1], x[1], y[0], x[0]};
        tx = AW'(x >> 6); ty = AW'(y >> 6); step = pitch << 5;
      end
      default: ;
    endcase
    if (mode == TM_LINEAR)
      raw = base + AW'(y) * pitch + AW'(ub);
    else
      raw = base + ty * step + (tx << TILE_BYTES_LOG2) + AW'(offs);
  end

  // channel swizzle on the finished address
  always_comb begin
    addr = raw;
    if (swz && mode == TM_X) addr[6] = raw[6] ^ raw[9] ^ raw[10];
    if (swz && mode == TM_Y) addr[6] = raw[6] ^ raw[9];
  end
endmodule

// File: rtl/tile_addr_walker.sv
module tile_addr_walker
  import tile_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 14
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [1:0]     cfg_mode,
  input  logic [2:0]     cfg_bpe_log2,
  input  logic [AW-1:0]  cfg_base,
  input  logic [AW-1:0]  cfg_pitch,
  input  logic           cfg_swz,
  input  logic           start,
  input  logic [CW-1:0]  org_x,
  input  logic [CW-1:0]  org_y,
  input  logic [CW-1:0]  rect_w,
  input  logic [CW-1:0]  rect_h,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [AW-1:0]  out_addr,
  output logic           done,
  output logic           err,
  output logic [AW-1:0]  surf_pitch,
  output logic [AW-1:0]  surf_bytes
);
  walk_state_e   st;
  tile_mode_e    r_mode;
  logic [2:0]    r_bpe;
  logic          r_swz;
  logic [AW-1:0] r_base, r_pitch;
  logic [CW-1:0] x0, x_last, y_last, cx, cy;
  logic          cfg_ok, empty, last_x, last_el;

  tile_geom #(.AW(AW), .CW(CW)) geom_i (
    .mode(tile_mode_e'(cfg_mode)), .bpe_log2(cfg_bpe_log2),
    .width(rect_w), .height(rect_h), .pitch(cfg_pitch),
    .size_pitch(surf_pitch), .size_bytes(surf_bytes), .legal(cfg_ok)
  );

  tile_addr_map #(.AW(AW), .CW(CW)) map_i (
    .mode(r_mode), .bpe_log2(r_bpe), .swz(r_swz), .base(r_base),
    .pitch(r_pitch), .x(cx), .y(cy), .addr(out_addr)
  );

  assign empty     = (rect_w == '0) || (rect_h == '0);
  assign last_x    = (cx == x_last);
  assign last_el   = last_x && (cy == y_last);
  assign out_valid = (st == WK_RUN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= WK_IDLE; done <= 1'b0; err <= 1'b0;
      r_mode <= TM_LINEAR; r_bpe <= '0; r_swz <= 1'b0;
      r_base <= '0; r_pitch <= '0;
      x0 <= '0; x_last <= '0; y_last <= '0; cx <= '0; cy <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        WK_IDLE: if (start) begin
          err <= !cfg_ok;
          if (cfg_ok && empty) done <= 1'b1;
          if (cfg_ok && !empty) begin
            st      <= WK_RUN;
            r_mode  <= tile_mode_e'(cfg_mode);
            r_bpe   <= cfg_bpe_log2;
            r_swz   <= cfg_swz;
            r_base  <= cfg_base;
            r_pitch <= cfg_pitch;
            x0      <= org_x;
            cx      <= org_x;
            cy      <= org_y;
            x_last  <= org_x + rect_w - CW'(1);
            y_last  <= org_y + rect_h - CW'(1);
          end
        end
        WK_RUN: if (out_ready) begin
          if (last_el) begin
            st <= WK_IDLE; done <= 1'b1;
          end else if (last_x) begin
            cx <= x0; cy <= cy + CW'(1);
          end else begin
            cx <= cx + CW'(1);
          end
        end
        default: st <= WK_IDLE;
      endcase
    end
  end

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr));
  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !out_valid);
  assert_err_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!start || out_valid) |=> $stable(err));
  assert_zero_area_R12: assert property (@(posedge clk) disable iff (!rst_n)
    start && !out_valid && (rect_w == '0) |=> !out_valid);
endmodule

// File: tb/tile_addr_walker_tb.sv
module tile_addr_walker_tb_top;
  localparam int AW = 32;
  localparam int CW = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] cfg_mode = '0;
  logic [2:0] cfg_bpe_log2 = '0;
  logic [AW-1:0] cfg_base = '0, cfg_pitch = '0;
  logic cfg_swz = 1'b0, start = 1'b0, out_ready = 1'b0;
  logic [CW-1:0] org_x = '0, org_y = '0, rect_w = '0, rect_h = '0;
  logic out_valid, done, err;
  logic [AW-1:0] out_addr, surf_pitch, surf_bytes;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [31:0] exp_a [0:63];
  int exp_n = 0;

  always #5 clk = ~clk;

  tile_addr_walker #(.AW(AW), .CW(CW)) dut_i (
    .clk, .rst_n, .cfg_mode, .cfg_bpe_log2, .cfg_base, .cfg_pitch, .cfg_swz,
    .start, .org_x, .org_y, .rect_w, .rect_h, .out_valid, .out_ready,
    .out_addr, .done, .err, .surf_pitch, .surf_bytes
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, expv);
    end
  endtask

  function automatic logic [31:0] ref_addr(input int m, input int b, input int s,
      input logic [31:0] base, input logic [31:0] pitch, input int x, input int y);
    logic [31:0] a, off;
    int ub = x << b;
    int u, v;
    a = base;
    case (m)
      0: a = base + y * pitch + ub;
      1: a = base + (y / 8) * pitch * 8 + (ub / 512) * 4096 + (y % 8) * 512 + ub % 512;
      2: a = base + (y / 32) * pitch * 32 + (ub / 128) * 4096
             + ((ub % 128) / 16) * 512 + (y % 32) * 16 + ub % 16;
      default: begin
        u = x % 64; v = y % 64;
        off = (u & 1) | ((v & 1) << 1) | (((u >> 1) & 1) << 2) | (((v >> 1) & 1) << 3)
            | (((u >> 2) & 1) << 4) | ((v >> 2) << 5) | ((u >> 3) << 9);
        a = base + (y / 64) * pitch * 32 + (x / 64) * 4096 + off;
      end
    endcase
    if (s != 0 && m == 1) a[6] = a[6] ^ a[9] ^ a[10];
    if (s != 0 && m == 2) a[6] = a[6] ^ a[9];
    return a;
  endfunction

  task automatic start_walk(input int m, input int b, input int s, input logic [31:0] base,
      input logic [31:0] pitch, input int ox, input int oy, input int w, input int h);
    @(negedge clk);
    cfg_mode = 2'(m); cfg_bpe_log2 = 3'(b); cfg_swz = s[0];
    cfg_base = base; cfg_pitch = pitch;
    org_x = CW'(ox); org_y = CW'(oy); rect_w = CW'(w); rect_h = CW'(h);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    exp_n = 0;
    for (int j = 0; j < h; j++)
      for (int i = 0; i < w; i++) begin
        exp_a[exp_n] = ref_addr(m, b, s, base, pitch, ox + i, oy + j);
        exp_n++;
      end
  endtask

  // collect every handshake, compare, then check the done pulse (R7, R8)
  task automatic drain(input string req, input int pat);
    int k = 0, cyc = 0;
    bit held = 0;
    logic [31:0] ha = '0;
    while (k < exp_n && cyc < 2000) begin
      @(negedge clk);
      cyc++;
      if (held) chk(out_valid && out_addr == ha, "R8 hold", out_addr, ha);
      out_ready = (pat == 0) ? 1'b1 : (cyc % 3 != 0);
      held = 0;
      if (out_valid) begin
        if (out_ready) begin
          chk(out_addr == exp_a[k], req, out_addr, exp_a[k]);
          k++;
        end else begin
          held = 1; ha = out_addr;
        end
      end
    end
    chk(k == exp_n, "R7 count", 32'(k), 32'(exp_n));
    @(negedge clk);
    out_ready = 1'b0;
    chk(done && !out_valid, "R7 done pulse", {30'd0, done, out_valid}, 32'd2);
    @(negedge clk);
    chk(!done, "R7 done one cycle", 32'(done), 32'd0);
  endtask

  task automatic t_reset;
    chk(!out_valid && !done && !err, "R7 reset", {29'd0, out_valid, done, err}, 32'd0);
  endtask

  task automatic t_sweep;
    int ox, oy;
    string tag;
    for (int m = 0; m < 4; m++)
      for (int b = 0; b < 5; b++)
        for (int s = 0; s < 2; s++) begin
          if (m == 3 && b != 0) continue;
          case (m)
            0: begin ox = 5; oy = 3; tag = "R1 linear"; end
            1: begin ox = (512 >> b) - 2; oy = 7; tag = (s != 0) ? "R6 X swizzle" : "R2/R5 X"; end
            2: begin ox = (128 >> b) - 2; oy = 31; tag = (s != 0) ? "R6 Y swizzle" : "R3/R5 Y"; end
            default: begin ox = 62; oy = 63; tag = "R4/R5 W"; end
          endcase
          start_walk(m, b, s, 32'h0012_0000, 32'd4096, ox, oy, 4, 3);
          drain(tag, s);
        end
  endtask

  task automatic t_start_ignored;
    start_walk(2, 2, 1, 32'h0008_0000, 32'd1024, 30, 30, 2, 3);
    @(negedge clk);
    cfg_mode = 2'd1; cfg_base = 32'h0; org_x = CW'(1); rect_w = CW'(5); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    drain("R9 start ignored", 0);
  endtask

  task automatic t_err(input int m, input int b, input logic [31:0] pitch, input string req);
    @(negedge clk);
    cfg_mode = 2'(m); cfg_bpe_log2 = 3'(b); cfg_pitch = pitch;
    rect_w = CW'(2); rect_h = CW'(2); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(err && !out_valid, req, {30'd0, err, out_valid}, 32'd2);
    @(negedge clk);
    chk(!done && !out_valid && err, {req, " no walk"}, {29'd0, done, out_valid, err}, 32'd1);
  endtask

  task automatic t_err_clear;
    start_walk(0, 0, 0, 32'h100, 32'd64, 0, 0, 1, 1);
    chk(!err, "R10 clear", 32'(err), 32'd0);
    drain("R1 after error", 0);
  endtask

  task automatic t_zero;
    start_walk(2, 0, 0, 32'h0, 32'd128, 3, 3, 0, 4);
    chk(done && !out_valid, "R12 zero area", {30'd0, done, out_valid}, 32'd2);
    @(negedge clk);
    chk(!done && !out_valid, "R12 quiet", {30'd0, done, out_valid}, 32'd0);
  endtask

  task automatic t_size(input int m, input int b, input int w, input int h,
      input logic [31:0] ep, input logic [31:0] eb);
    @(negedge clk);
    cfg_mode = 2'(m); cfg_bpe_log2 = 3'(b); rect_w = CW'(w); rect_h = CW'(h);
    #1;
    chk(surf_pitch == ep, "R11 pitch", surf_pitch, ep);
    chk(surf_bytes == eb, "R11 bytes", surf_bytes, eb);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_sweep();
    t_start_ignored();
    t_err(3, 2, 32'd4096, "R10 W wide element");
    t_err(2, 0, 32'd4100, "R10 Y pitch");
    t_err(0, 5, 32'd4096, "R10 bpe range");
    t_err_clear();
    t_zero();
    t_size(2, 2, 100, 40, 32'd512, 32'd32768);
    t_size(3, 0, 100, 70, 32'd256, 32'd16384);
    t_size(1, 0, 1000, 9, 32'd1024, 32'd16384);
    t_size(0, 3, 10, 5, 32'd80, 32'd400);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule